// File: doc/BRIEF.md
# Soft-Start and Power-Good Sequencer

This block takes a buck regulator controller from an enable request to steady regulation. It watches two supply flags that come from outside comparators: one says the bias supply is above its upper power-on threshold, the other says it is below its lower threshold. It produces a digital reference code for an outside DAC, a drive-enable for the PWM stage, a power-good release, a soft-start status flag and a one-cycle pulse that clears the fault latches of the neighbouring protection blocks.

A start is allowed only after the supply has been seen low and then high again, which gives the power-on gate its hysteresis. The reference code then climbs one step at a time from zero to full scale over a programmed ramp time. A second and longer timer, started by the enable, decides when power-good is released. Dropping the enable cuts the drive at once and disarms the sequencer. Only a new low-supply event can arm it again, and that event also clears all fault latches.

All times are in clock cycles, derived from the clock rate parameter `CLK_KHZ` and the microsecond parameters `RAMP_US` and `PG_US`.

Top module: `soft_start_seq`

## Requirements
- R1: After reset the block is disarmed. With `run_req` and `sup_hi` both high but no earlier `sup_lo`, `drv_enable` stays 0, `ref_code` stays 0 and `pg_release` stays 0.
- R2: While ramping, `ref_code` rises by exactly 1 every STEP cycles and never falls. STEP = max(1, floor(floor(CLK_KHZ*RAMP_US/1000)/1023)) for a 10-bit code. `drv_enable` goes high one edge after the start condition is sampled (armed, `run_req`=1, `sup_hi`=1). Code 1023 is reached 1023*STEP edges after `drv_enable` rises, and the code then holds there.
- R3: Counting the first edge at which `run_req` is sampled high while armed as edge 1, `pg_release` goes high after edge PG = floor(CLK_KHZ*PG_US/1000), provided the ramp is complete by then.
- R4: When `run_req` is low, `drv_enable` is low in the same cycle, with no clock edge needed. At the next edge `ref_code` is 0 and `pg_release` is 0. Raising `run_req` again does not restart the ramp until the block is re-armed.
- R5: `sup_lo` sampled high in any state stops the sequence: after that edge `drv_enable`, `pg_release` and `ref_code` are 0 and the block is armed.
- R6: `clear_faults` is high for exactly one cycle, after the first edge that samples `sup_lo` high while the block is not armed. It does not repeat while `sup_lo` is held.
- R7: `in_softstart` is high exactly while `drv_enable` is high and `pg_release` is low, so it is never high at the same time as `pg_release`.
- R8: `pg_release` is never high unless `ref_code` is at full scale (1023).
- R9: When `sup_lo` and `sup_hi` are both high, `sup_lo` wins: no ramp starts until `sup_lo` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req | input | 1 | Synchronous enable request |
| sup_hi | input | 1 | Supply is above the upper power-on threshold |
| sup_lo | input | 1 | Supply is below the lower power-on threshold |
| ref_code | output | CODE_W | Reference code for the DAC, 0 to full scale |
| drv_enable | output | 1 | PWM drive enable |
| pg_release | output | 1 | Power-good released |
| in_softstart | output | 1 | High from ramp start until power-good release |
| clear_faults | output | 1 | One-cycle pulse that clears the fault latches |

## Verification
The hardest situation to reach from the ports is a re-arm that lands in the middle of a ramp while the enable and the upper supply flag are still high. In that case the code must drop to zero and restart at once, with exactly one clear pulse. The stimulus arms the block, runs a couple of hundred cycles into the ramp and then asserts the low-supply flag for two cycles before it releases it. A related case holds both supply flags high together after a fresh enable. This shows that the low flag keeps the block armed and idle until it is released.

// File: rtl/sss_pkg.sv
package sss_pkg;

    typedef enum logic [1:0] {
        ST_UNARMED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RAMP    = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       clr;
    } seq_ctrl_t;

    function automatic int step_div(input int clk_khz, input int ramp_us, input int full);
        int cyc;
        cyc = (clk_khz * ramp_us) / 1000;
        return ((cyc / full) < 1) ? 1 : (cyc / full);
    endfunction

    function automatic int pg_cycles(input int clk_khz, input int pg_us);
        int cyc;
        cyc = (clk_khz * pg_us) / 1000;
        return (cyc < 1) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/sss_prescale.sv
module sss_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step
);
    localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        step  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
            step  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sss_ramp.sv
module sss_ramp #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              full
);
    localparam logic [CODE_W-1:0] TOP = '1;

    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (clr)                        code_d = '0;
        else if (step && code_q != TOP) code_d = code_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code = code_q;
    assign full = (code_q == TOP);
endmodule

// File: rtl/sss_pgtimer.sv
module sss_pgtimer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] END_VAL = TW'(LIMIT);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                   cnt_d = '0;
        else if (cnt_q != END_VAL) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == END_VAL);
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
    import sss_pkg::*;
#(
    parameter int CLK_KHZ = 250000,
    parameter int RAMP_US = 1500,
    parameter int PG_US   = 2750,
    parameter int CODE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              sup_hi,
    input  logic              sup_lo,
    output logic [CODE_W-1:0] ref_code,
    output logic              drv_enable,
    output logic              pg_release,
    output logic              in_softstart,
    output logic              clear_faults
);
    localparam int FULL_CODE = (1 << CODE_W) - 1;
    localparam int STEP_DIV  = step_div(CLK_KHZ, RAMP_US, FULL_CODE);
    localparam int PG_CYC    = pg_cycles(CLK_KHZ, PG_US);

    seq_ctrl_t ctl_d, ctl_q;
    logic      ramp_full, ramp_step, ramp_clr, pg_done, pg_clr, driving;

    // next-state: low supply has priority and re-arms from anywhere
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.clr = 1'b0;
        if (sup_lo) begin
            ctl_d.st  = ST_ARMED;
            ctl_d.clr = (ctl_q.st != ST_ARMED);
        end else begin
            unique case (ctl_q.st)
                ST_UNARMED: ctl_d.st = ST_UNARMED;
                ST_ARMED:   if (run_req && sup_hi) ctl_d.st = ST_RAMP;
                ST_RAMP: begin
                    if (!run_req)       ctl_d.st = ST_UNARMED;
                    else if (ramp_full) ctl_d.st = ST_RUN;
                end
                ST_RUN:     if (!run_req) ctl_d.st = ST_UNARMED;
                default:    ctl_d.st = ST_UNARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_UNARMED;
            ctl_q.clr <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ramp_clr = !(ctl_d.st == ST_RAMP || ctl_d.st == ST_RUN);
    assign pg_clr   = !run_req || (ctl_q.st == ST_UNARMED);
    assign driving  = (ctl_q.st == ST_RAMP) || (ctl_q.st == ST_RUN);

    sss_prescale #(.DIV(STEP_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.st == ST_RAMP),
        .step (ramp_step)
    );

    sss_ramp #(.CODE_W(CODE_W)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ramp_clr),
        .step (ramp_step),
        .code (ref_code),
        .full (ramp_full)
    );

    sss_pgtimer #(.LIMIT(PG_CYC)) u_pg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pg_clr),
        .done (pg_done)
    );

    assign drv_enable   = driving && run_req;
    assign pg_release   = (ctl_q.st == ST_RUN) && pg_done;
    assign in_softstart = drv_enable && !pg_release;
    assign clear_faults = ctl_q.clr;
endmodule

// File: rtl/soft_start_seq_chk.sv
module soft_start_seq_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_req,
    input logic              sup_hi,
    input logic              sup_lo,
    input logic [CODE_W-1:0] ref_code,
    input logic              drv_enable,
    input logic              pg_release,
    input logic              in_softstart,
    input logic              clear_faults
);
    localparam logic [CODE_W-1:0] TOPC = '1;

    a_r2_code_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code != $past(ref_code)) |-> (ref_code == $past(ref_code) + 1'b1 || ref_code == '0));

    a_r8_pg_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        pg_release |-> (ref_code == TOPC));

    a_r6_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        clear_faults |=> !clear_faults);

    a_r7_softstart_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_softstart && pg_release));

    a_r4_drop_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> (ref_code == '0 && !pg_release));

    a_r5_low_supply_stops: assert property (@(posedge clk) disable iff (!rst_n)
        sup_lo |=> (ref_code == '0 && !drv_enable));

    a_r1_start_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_enable) |-> $past(sup_hi));
endmodule

bind soft_start_seq soft_start_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req     (run_req),
    .sup_hi      (sup_hi),
    .sup_lo      (sup_lo),
    .ref_code    (ref_code),
    .drv_enable  (drv_enable),
    .pg_release  (pg_release),
    .in_softstart(in_softstart),
    .clear_faults(clear_faults)
);

// File: tb/sim_soft_start_seq.sv
`timescale 1ns/1ps
module sim_soft_start_seq;
    localparam int CLK_KHZ = 4000;
    localparam int RAMP_US = 1500;
    localparam int PG_US   = 2750;
    localparam int CODE_W  = 10;
    localparam int FULL    = 1023;
    localparam int RAMP_C  = CLK_KHZ * RAMP_US / 1000;
    localparam int STEP    = (RAMP_C / FULL) < 1 ? 1 : (RAMP_C / FULL);
    localparam int PGC     = CLK_KHZ * PG_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, sup_hi = 1'b0, sup_lo = 1'b0;
    logic [CODE_W-1:0] ref_code;
    logic drv_enable, pg_release, in_softstart, clear_faults;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    soft_start_seq #(.CLK_KHZ(CLK_KHZ), .RAMP_US(RAMP_US), .PG_US(PG_US), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .sup_hi(sup_hi), .sup_lo(sup_lo),
        .ref_code(ref_code), .drv_enable(drv_enable), .pg_release(pg_release),
        .in_softstart(in_softstart), .clear_faults(clear_faults)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(ref_code == 0, "R1 reset code", ref_code, 0);
        chk(!drv_enable && !pg_release && !in_softstart && !clear_faults,
            "R1 reset flags", {drv_enable, pg_release, in_softstart, clear_faults}, 0);
    endtask

    task automatic t_no_arm();
        int bad = 0;
        run_req = 1; sup_hi = 1;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (drv_enable || ref_code != 0 || pg_release || clear_faults) bad++;
        end
        chk(bad == 0, "R1 no start without low supply", bad, 0);
        run_req = 0; sup_hi = 0;
        tick();
    endtask

    task automatic arm(output int pulses);
        pulses = 0;
        sup_hi = 0; sup_lo = 1;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (clear_faults) pulses++;
        end
        sup_lo = 0;
        for (int i = 0; i < 2; i++) begin
            tick();
            if (clear_faults) pulses++;
        end
    endtask

    task automatic t_arm();
        int p;
        arm(p);
        chk(p == 1, "R6 single clear pulse", p, 1);
        chk(!drv_enable && ref_code == 0, "R1 armed idle", drv_enable, 0);
    endtask

    task automatic t_full_seq();
        int n = 0, n_pwm = -1, n_full = -1, n_pg = -1;
        int prev = 0, last = 1, bad_step = 0, bad_ss = 0, bad_pg = 0;
        run_req = 1; sup_hi = 1;
        while (n < PGC + 1000 && n_pg < 0) begin
            tick();
            n++;
            if (drv_enable && n_pwm < 0) n_pwm = n;
            if (int'(ref_code) != prev) begin
                if (int'(ref_code) != prev + 1 || (n - last) != STEP) bad_step++;
                last = n;
                prev = int'(ref_code);
            end
            if (ref_code == FULL && n_full < 0) n_full = n;
            if (pg_release && n_pg < 0) n_pg = n;
            if (pg_release && ref_code != FULL) bad_pg++;
            if (in_softstart != (drv_enable && !pg_release)) bad_ss++;
        end
        chk(n_pwm == 1, "R2 drive rises one edge after start", n_pwm, 1);
        chk(bad_step == 0, "R2 code steps by one every STEP cycles", bad_step, 0);
        chk(n_full == 1 + FULL * STEP, "R2 full-scale time", n_full, 1 + FULL * STEP);
        chk(n_pg == PGC, "R3 power-good delay", n_pg, PGC);
        chk(bad_ss == 0, "R7 soft-start flag", bad_ss, 0);
        chk(bad_pg == 0, "R8 power-good only at full code", bad_pg, 0);
        for (int i = 0; i < 20; i++) tick();
        chk(ref_code == FULL && pg_release && !in_softstart, "R2 code holds at full", ref_code, FULL);
    endtask

    task automatic t_en_drop();
        int bad = 0;
        run_req = 0;
        #1;
        chk(drv_enable == 0, "R4 drive drops without edge", drv_enable, 0);
        tick();
        chk(ref_code == 0, "R4 code cleared", ref_code, 0);
        chk(pg_release == 0, "R4 power-good withdrawn", pg_release, 0);
        run_req = 1;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (drv_enable || ref_code != 0) bad++;
        end
        chk(bad == 0, "R4 no restart without re-arm", bad, 0);
        run_req = 0;
        tick();
    endtask

    task automatic t_rearm_mid();
        int p;
        arm(p);
        run_req = 1; sup_hi = 1;
        for (int i = 0; i < 200; i++) tick();
        chk(drv_enable && ref_code > 0, "R2 ramp under way", ref_code, 1);
        sup_lo = 1;
        tick();
        chk(ref_code == 0 && !drv_enable, "R5 low supply stops ramp", ref_code, 0);
        chk(clear_faults == 1, "R6 clear on re-arm", clear_faults, 1);
        tick();
        chk(clear_faults == 0, "R6 clear not repeated", clear_faults, 0);
        sup_lo = 0;
        tick();
        chk(drv_enable == 1, "R5 restart after re-arm", drv_enable, 1);
        chk(ref_code == 0, "R5 restart from zero", ref_code, 0);
    endtask

    task automatic t_priority();
        int bad = 0;
        run_req = 0;
        tick();
        run_req = 1; sup_hi = 1; sup_lo = 1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (drv_enable || pg_release) bad++;
        end
        chk(bad == 0, "R9 low flag wins over high flag", bad, 0);
        sup_lo = 0;
        tick();
        chk(drv_enable == 1, "R9 start after low flag released", drv_enable, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_no_arm();
        t_arm();
        t_full_seq();
        t_en_drop();
        t_rearm_mid();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule